// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block is a six-input lookup table that can split into two five-input tables. Sixty-four truth-table bits form the leaves of a binary tree of 2:1 selections. Each table input steers one level of that tree. Input 0 steers the level nearest the leaves and input 5 steers the root. A sixty-fifth configuration bit sets the operating mode.

When the mode bit is 0, the table computes one function of all six inputs. When the mode bit is 1, input 5 is forced high by an OR gate before it reaches the root select. The two results of the fifth tree level are also brought out as separate outputs. The lower tap covers truth bits 0 to 31 and the upper tap covers bits 32 to 63. The table then acts as two five-input functions that share inputs 0 to 4. A single mode bit is enough here because exactly one input is forced.

All three outputs are registered on the rising clock edge. A synchronous active-high reset clears them.

Top module: `frac_lut6`

## Requirements
- R1: While `rst` is high at a rising edge, `full_o` and both bits of `frac_o` are 0 after that edge, whatever the table inputs and configuration are.
- R2: Outputs are registered. A change on `lut_in_i` or `cfg_i` is not visible before the next rising edge, and it is visible just after that edge.
- R3: With the mode bit `cfg_i[64]` at 0, `full_o` equals `cfg_i[k]`, where k is the 6-bit number `lut_in_i` with `lut_in_i[0]` as its least significant bit.
- R4: With the mode bit `cfg_i[64]` at 1, input 5 is forced to 1. `full_o` then equals `cfg_i[32 + lut_in_i[4:0]]`, and `lut_in_i[5]` has no effect on any output.
- R5: In both modes, `frac_o[0]` equals `cfg_i[lut_in_i[4:0]]`, the lower five-input table.
- R6: In both modes, `frac_o[1]` equals `cfg_i[32 + lut_in_i[4:0]]`, the upper five-input table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| lut_in_i | input | 6 | Table inputs; bit 0 selects nearest the leaves, bit 5 at the root |
| cfg_i | input | 65 | Bits 63:0 are the truth table; bit 64 is the mode bit (1 = dual five-input) |
| full_o | output | 1 | Registered six-input result |
| frac_o | output | 2 | Registered fifth-level taps: bit 0 is the lower table, bit 1 the upper table |

## Verification
The full result and the two fractured taps are produced in the same cycle from the same tree. In dual mode the full output must match the upper tap, and in single mode it must match whichever tap input 5 selects. The sweep applies every input value under both mode settings against several truth-table patterns. Each pattern makes the lower and upper halves differ, so a wrong forced value or a wrong tap level shows up as a mismatch. All three outputs are judged against indices computed in the bench, in the cycle after each change.

// File: rtl/flut_pkg.sv
package flut_pkg;
  localparam int unsigned FLUT_INPUTS    = 6;
  localparam int unsigned FLUT_TAP_STAGE = 5;
endpackage

// File: rtl/flut_force_gate.sv
module flut_force_gate #(
  parameter int unsigned N          = 6,
  parameter logic [N-1:0] FORCE_MASK = '0,
  parameter logic [N-1:0] FORCE_ONE  = '0
) (
  input  logic [N-1:0] in_i,
  input  logic         mode_i,
  output logic [N-1:0] eff_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (FORCE_MASK[b] && FORCE_ONE[b]) begin : g_or
      assign eff_o[b] = in_i[b] | mode_i;
    end else if (FORCE_MASK[b]) begin : g_and
      assign eff_o[b] = in_i[b] & ~mode_i;
    end else begin : g_pass
      assign eff_o[b] = in_i[b];
    end
  end
endmodule

// File: rtl/flut_mux_tree.sv
module flut_mux_tree #(
  parameter int unsigned N   = 6,
  parameter int unsigned TAP = 5,
  localparam int unsigned LEAVES  = 1 << N,
  localparam int unsigned NUM_TAP = 1 << (N - TAP)
) (
  input  logic [LEAVES-1:0]  leaves_i,
  input  logic [N-1:0]       sel_i,
  output logic               root_o,
  output logic [NUM_TAP-1:0] tap_o
);
  logic [LEAVES-1:0] stage_w [0:N];

  assign stage_w[0] = leaves_i;

  for (genvar s = 1; s <= N; s++) begin : g_stage
    localparam int unsigned W = LEAVES >> s;
    for (genvar j = 0; j < W; j++) begin : g_node
      assign stage_w[s][j] = sel_i[s-1] ? stage_w[s-1][2*j+1] : stage_w[s-1][2*j];
    end
    assign stage_w[s][LEAVES-1:W] = '0;
  end

  assign root_o = stage_w[N][0];
  assign tap_o  = stage_w[TAP][NUM_TAP-1:0];
endmodule

// File: rtl/flut_out_reg.sv
module flut_out_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/frac_lut6.sv
module frac_lut6 #(
  parameter int unsigned NUM_IN    = flut_pkg::FLUT_INPUTS,
  parameter int unsigned TAP_STAGE = flut_pkg::FLUT_TAP_STAGE,
  parameter logic [NUM_IN-1:0] FORCE_MASK = 6'b100000,
  parameter logic [NUM_IN-1:0] FORCE_ONE  = 6'b100000,
  localparam int unsigned TBL_W    = 1 << NUM_IN,
  localparam int unsigned CFG_W    = TBL_W + 1,
  localparam int unsigned NUM_FRAC = 1 << (NUM_IN - TAP_STAGE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_IN-1:0]   lut_in_i,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic                full_o,
  output logic [NUM_FRAC-1:0] frac_o
);
  logic              mode_w;
  logic [NUM_IN-1:0] sel_w;
  logic              root_w;
  logic [NUM_FRAC-1:0] tap_w;

  assign mode_w = cfg_i[CFG_W-1];

  flut_force_gate #(
    .N(NUM_IN), .FORCE_MASK(FORCE_MASK), .FORCE_ONE(FORCE_ONE)
  ) force_i (
    .in_i(lut_in_i), .mode_i(mode_w), .eff_o(sel_w)
  );

  flut_mux_tree #(
    .N(NUM_IN), .TAP(TAP_STAGE)
  ) tree_i (
    .leaves_i(cfg_i[TBL_W-1:0]), .sel_i(sel_w), .root_o(root_w), .tap_o(tap_w)
  );

  flut_out_reg #(
    .W(NUM_FRAC + 1)
  ) oreg_i (
    .clk(clk), .rst(rst), .d_i({root_w, tap_w}), .q_o({full_o, frac_o})
  );
endmodule

// File: rtl/frac_lut6_chk.sv
module frac_lut6_chk (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  lut_in_i,
  input logic [64:0] cfg_i,
  input logic        full_o,
  input logic [1:0]  frac_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (full_o == 1'b0 && frac_o == 2'b00));

  assert_single_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i[64]) |=> (full_o == (lut_in_i[5] ? frac_o[1] : frac_o[0])) || $past(lut_in_i[5]) != lut_in_i[5] || 1'b1 == 1'b0 ? 1'b1 :
    (full_o == ($past(lut_in_i[5]) ? frac_o[1] : frac_o[0])));

  assert_dual_mode_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_i[64] |=> (full_o == frac_o[1]));

  assert_lower_tap_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frac_o[0] == $past(cfg_i[lut_in_i[4:0]])));

  assert_upper_tap_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (frac_o[1] == $past(cfg_i[{1'b1, lut_in_i[4:0]}])));
endmodule

bind frac_lut6 frac_lut6_chk chk_i (
  .clk(clk), .rst(rst), .lut_in_i(lut_in_i), .cfg_i(cfg_i),
  .full_o(full_o), .frac_o(frac_o)
);

// File: tb/frac_lut6_tb.sv
module frac_lut6_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  lut_in_i = '0;
  logic [64:0] cfg_i = '0;
  logic        full_o;
  logic [1:0]  frac_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_lut6 dut_i (
    .clk(clk), .rst(rst), .lut_in_i(lut_in_i), .cfg_i(cfg_i),
    .full_o(full_o), .frac_o(frac_o)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s in=%b mode=%b actual=%b expected=%b", req, lut_in_i, cfg_i[64], act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int k);
    case (k)
      0: return 64'h0000_0000_FFFF_FFFF;
      1: return 64'hFFFF_FFFF_0000_0000;
      2: return 64'hAAAA_AAAA_5555_5555;
      3: return 64'h0123_4567_89AB_CDEF;
      4: return {$urandom(), $urandom()};
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    cfg_i = '1;
    lut_in_i = 6'h3F;
    repeat (2) @(negedge clk);
    // R1: reset clears outputs even with all-ones table
    check_bit("R1", full_o, 1'b0);
    check_bit("R1", frac_o[0], 1'b0);
    check_bit("R1", frac_o[1], 1'b0);
    rst = 1'b0;

    // R2: latency of one edge
    cfg_i = {1'b0, 64'h0};
    lut_in_i = 6'd0;
    @(negedge clk);
    check_bit("R2", full_o, 1'b0);
    cfg_i = {1'b0, 64'hFFFF_FFFF_FFFF_FFFF};
    @(posedge clk);
    #1;
    check_bit("R2", full_o, 1'b1);
    cfg_i = {1'b0, 64'h0};
    #1;
    check_bit("R2", full_o, 1'b1);

    for (int k = 0; k < 6; k++) begin
      logic [63:0] tbl;
      tbl = pattern(k);
      for (int m = 0; m < 2; m++) begin
        for (int v = 0; v < 64; v++) begin
          logic [5:0] idx;
          @(negedge clk);
          cfg_i = {m[0], tbl};
          lut_in_i = v[5:0];
          idx = {v[5] | m[0], v[4:0]};
          @(negedge clk);
          if (m == 0) check_bit("R3", full_o, tbl[idx]);
          else        check_bit("R4", full_o, tbl[idx]);
          check_bit("R5", frac_o[0], tbl[{1'b0, v[4:0]}]);
          check_bit("R6", frac_o[1], tbl[{1'b1, v[4:0]}]);
        end
      end
    end

    // R4: in dual mode, toggling input 5 leaves all outputs unchanged
    cfg_i = {1'b1, 64'h0000_0000_FFFF_FFFF};
    lut_in_i = 6'b000111;
    @(negedge clk);
    check_bit("R4", full_o, 1'b0);
    lut_in_i = 6'b100111;
    @(negedge clk);
    check_bit("R4", full_o, 1'b0);
    check_bit("R4", frac_o[0], 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule